// File: doc/BRIEF.md
# Dynamic bus-sizing transfer sequencer

This block is the bus-master end of a 16-bit external data bus whose slaves may be either 8 or 16 bits wide. It takes one internal request at a time. A request carries an operand of one, two or four bytes, a start address and a direction. The block splits the request into as many external bus cycles as the slave needs. The slave reports its width on every cycle through a two-line acknowledge, so the sequencer learns the width as it goes. It does not need the width in advance.

While a request is in flight, the sequencer holds its strobe high. On each cycle it presents an address and a two-bit code for the number of bytes still to move. When an acknowledge arrives, it moves one or two bytes, lowers the remaining count and advances the address. The next cycle then starts on the following clock. Write bytes are steered onto the data lines from a left-aligned shift register. Read bytes are shifted in from most significant to least significant. When the count reaches zero, the sequencer drops its strobe and pulses a completion flag with the right-justified read result.

Top module: `bus_sizer`

## Requirements
- R1: After reset, `busy`, `bus_strobe`, `bus_write` and `done` are all low.
- R2: On every cycle, `bus_size` encodes the bytes still to move: 2'b00 for four, 2'b11 for three, 2'b10 for two, 2'b01 for one. `req_size` uses the same code for the request: 01 byte, 10 word, 00 long word.
- R3: `bus_ack[1]` alone marks a 16-bit port, and `bus_ack[0]` alone marks an 8-bit port. When both are high, the cycle is treated as a 16-bit port cycle.
- R4: A word at an even address to a 16-bit port takes one cycle, with size 10 and `bus_addr[0]`=0. The word is read from, or written on, `bus_wdata`/`bus_rdata` bits 15:0.
- R5: A long word at an even address to an 8-bit port takes four cycles. Their size codes are 00, 11, 10, 01 at addresses +0, +1, +2, +3. The most significant byte moves first.
- R6: A long word at an even address to a 16-bit port takes two cycles, with sizes 00 then 10. The address advances by two between them.
- R7: An 8-bit port cycle reads its byte from `bus_rdata[15:8]`, and bits 7:0 are ignored. A 16-bit port cycle at an odd address moves one byte, read from bits 7:0.
- R8: On a write, `bus_wdata[15:8]` carries the most significant remaining byte. `bus_wdata[7:0]` carries the next one, or the same byte again when only one byte is left.
- R9: While no acknowledge arrives, the cycle stays pending, and address, size and strobe hold unchanged.
- R10: After the final acknowledge, `done` is high for exactly one cycle, in the cycle where `busy` is already low. `rdata` then holds the read operand, right-justified.
- R11: A request presented while `busy` is high is ignored. It produces no extra bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_size | input | 2 | Operand size code (01 byte, 10 word, 00 long word) |
| req_addr | input | AW | Start address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | High from the first bus cycle until the final acknowledge |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read operand, right-justified, valid with `done` |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Direction of the current cycle |
| bus_addr | output | AW | Address of the current cycle |
| bus_size | output | 2 | Remaining-byte code |
| bus_wdata | output | 16 | Write data lines |
| bus_rdata | input | 16 | Read data lines |
| bus_ack | input | 2 | Acknowledge: bit 1 for a 16-bit port, bit 0 for an 8-bit port |

## Verification
A wrong remaining count or address shows up on the pins one clock after an acknowledge, as a wrong size code or address on the follow-up cycle. It can also show as a cycle that should not exist, or one that is missing. A write byte steered from the wrong position shows on `bus_wdata` in the same cycle. A read byte taken from the wrong lane, or shifted into the wrong place, stays hidden until `done`, when `rdata` exposes it. The bench predicts every cycle, with its address, size and write data, for each port width. It includes wait states, doubled acknowledges and a request that arrives while the block is busy.

// File: rtl/bus_sizer.sv
module bus_sizer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_strobe,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic [1:0]    bus_ack
);

  logic          busy_q, done_q, wr_q;
  logic [2:0]    rem_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   sh_q, rd_q;

  wire       hit    = busy_q & (|bus_ack);
  wire       wide   = bus_ack[1] & ~addr_q[0] & (rem_q >= 3'd2);
  wire [2:0] step   = wide ? 3'd2 : 3'd1;
  wire [7:0] rbyte  = (bus_ack[1] & addr_q[0]) ? bus_rdata[7:0] : bus_rdata[15:8];
  wire [2:0] nbytes = {~|req_size, req_size};
  wire [5:0] lshift = {3'd4 - nbytes, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      sh_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && req_valid) begin
        busy_q <= 1'b1;
        wr_q   <= req_write;
        rem_q  <= nbytes;
        addr_q <= req_addr;
        sh_q   <= req_wdata << lshift;
        rd_q   <= '0;
      end else if (hit) begin
        rem_q  <= rem_q - step;
        addr_q <= addr_q + AW'(step);
        sh_q   <= wide ? {sh_q[15:0], 16'h0} : {sh_q[23:0], 8'h0};
        rd_q   <= wide ? {rd_q[15:0], bus_rdata} : {rd_q[23:0], rbyte};
        if (rem_q == step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign rdata      = rd_q;
  assign bus_strobe = busy_q;
  assign bus_write  = busy_q & wr_q;
  assign bus_addr   = addr_q;
  assign bus_size   = rem_q[1:0];
  assign bus_wdata  = {sh_q[31:24], (rem_q == 3'd1) ? sh_q[31:24] : sh_q[23:16]};

endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          bus_strobe,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [1:0]    bus_ack
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack == 2'b00) |=>
      (bus_strobe && $stable(bus_addr) && $stable(bus_size)));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack == 2'b01 && bus_size != 2'b01) |=>
      (bus_strobe && bus_addr == $past(bus_addr) + AW'(1)));

  p_size_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack == 2'b01 && bus_size == 2'b00) |=> (bus_size == 2'b11));

  p_word_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack[1] && !bus_addr[0] && bus_size == 2'b00) |=>
      (bus_strobe && bus_size == 2'b10 && bus_addr == $past(bus_addr) + AW'(2)));

  p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_ack != 2'b00 && bus_size == 2'b01) |=> (!bus_strobe && done));

endmodule

bind bus_sizer bus_sizer_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_bus_sizer.sv
`timescale 1ns/1ps
module test_bus_sizer;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_size = 2'b01;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          busy, done, bus_strobe, bus_write;
  logic [31:0]   rdata;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;
  logic [1:0]    bus_ack = 2'b00;

  bus_sizer #(.AW(AW)) i_bus_sizer (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [AW-1:0] a;
    logic [1:0]    sz;
    logic [15:0]   wd;
    logic          wr;
    string         tag;
  } cyc_t;

  cyc_t q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   port16 = 1'b0, ack_both = 1'b0;
  int   waitn = 0, wcnt = 0;

  function automatic logic [7:0] mem(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave model and monitor: pops one expected cycle per acknowledge
  always @(negedge clk) begin
    bus_ack = 2'b00;
    if (rst_n && bus_strobe) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected bus cycle", {16'h0, bus_addr}, 32'h0);
      end else begin
        chk(bus_addr == q[0].a, {q[0].tag, " addr"}, {16'h0, bus_addr}, {16'h0, q[0].a});
        chk(bus_size == q[0].sz, {q[0].tag, " R2 size"}, {30'h0, bus_size}, {30'h0, q[0].sz});
        chk(bus_write == q[0].wr, {q[0].tag, " dir"}, {31'h0, bus_write}, {31'h0, q[0].wr});
        if (q[0].wr)
          chk(bus_wdata == q[0].wd, {q[0].tag, " R8 wdata"}, {16'h0, bus_wdata}, {16'h0, q[0].wd});
        if (wcnt < waitn) begin
          wcnt++;
        end else begin
          wcnt = 0;
          if (port16) begin
            bus_ack   = ack_both ? 2'b11 : 2'b10;
            bus_rdata = bus_addr[0] ? {8'hEE, mem(bus_addr)} : {mem(bus_addr), mem(bus_addr + 1'b1)};
          end else begin
            bus_ack   = 2'b01;
            bus_rdata = {mem(bus_addr), 8'hEE};
          end
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] sz, input logic [AW-1:0] a, input bit w,
                        input logic [31:0] wd, input string tag, input bit inject);
    int n, k;
    logic [7:0]    b[5];
    logic [31:0]   exp;
    logic [AW-1:0] ad;
    bit two, seen;
    cyc_t it;
    n = (sz == 2'b00) ? 4 : int'(sz);
    for (int i = 0; i < 5; i++) b[i] = 8'h00;
    for (int i = 0; i < n; i++) b[i] = wd[8*(n-1-i) +: 8];
    exp = '0; k = 0; ad = a;
    while (k < n) begin
      two   = port16 && !ad[0] && (n - k >= 2);
      it.a  = ad;
      it.sz = 2'(n - k);
      it.wd = {b[k], (n - k == 1) ? b[k] : b[k+1]};
      it.wr = w;
      it.tag = tag;
      q.push_back(it);
      exp = two ? {exp[15:0], mem(ad), mem(ad + 1'b1)} : {exp[23:0], mem(ad)};
      k  += two ? 2 : 1;
      ad += two ? 2 : 1;
    end
    @(negedge clk);
    req_valid = 1'b1; req_size = sz; req_addr = a; req_write = w; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 300 && !seen; c++) begin
      if (inject && c == 1) begin
        req_valid = 1'b1; req_size = 2'b00; req_addr = 16'h7770; req_write = 1'b1;
      end
      if (inject && c == 3) req_valid = 1'b0;
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seen, {tag, " R10 done seen"}, {31'h0, seen}, 32'h1);
    chk(!busy, {tag, " R10 busy low with done"}, {31'h0, busy}, 32'h0);
    if (!w) chk(rdata == exp, {tag, " R7 R10 rdata"}, rdata, exp);
    chk(q.size() == 0, {tag, " cycle count"}, q.size(), 32'h0);
    @(negedge clk);
    chk(!done, {tag, " R10 done one cycle"}, {31'h0, done}, 32'h0);
    chk(!bus_strobe, {tag, " R11 no extra cycle"}, {31'h0, bus_strobe}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !bus_strobe && !done && !bus_write, "R1 reset state",
        {28'h0, busy, bus_strobe, done, bus_write}, 32'h0);
    rst_n = 1'b1;
    port16 = 1; run_op(2'b10, 16'h0100, 0, 0, "R4 word rd 16b", 0);
    port16 = 1; run_op(2'b10, 16'h0104, 1, 32'h0000_BEEF, "R4 word wr 16b", 0);
    port16 = 0; run_op(2'b00, 16'h0200, 0, 0, "R5 long rd 8b", 0);
    port16 = 1; run_op(2'b00, 16'h0300, 0, 0, "R6 long rd 16b", 0);
    port16 = 0; run_op(2'b00, 16'h0400, 1, 32'h1234_5678, "R5 R8 long wr 8b", 0);
    port16 = 1; run_op(2'b00, 16'h0408, 1, 32'hCAFE_F00D, "R6 R8 long wr 16b", 0);
    port16 = 1; run_op(2'b01, 16'h0501, 0, 0, "R7 byte rd odd 16b", 0);
    port16 = 1; run_op(2'b01, 16'h0503, 1, 32'h0000_00A5, "R8 byte wr odd 16b", 0);
    port16 = 0; run_op(2'b10, 16'h0600, 0, 0, "R2 word rd 8b", 0);
    port16 = 1; ack_both = 1; run_op(2'b00, 16'h0700, 0, 0, "R3 both acks", 0);
    ack_both = 0;
    port16 = 0; waitn = 3; run_op(2'b00, 16'h0800, 0, 0, "R9 wait states", 0);
    port16 = 1; run_op(2'b10, 16'h0810, 1, 32'h0000_1357, "R9 wait wr 16b", 0);
    waitn = 0;
    port16 = 0; run_op(2'b00, 16'h0900, 0, 0, "R11 busy inject", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule